// File: doc/BRIEF.md
# Per-Bit Read Delay Calibrator

This block trains the input delay of every read data line in one byte group so that the internal sampling clock edge falls in the middle of that line's data-valid window. While it works, the memory keeps returning an alternating training pattern on all lines. Sampled at one clock edge, a line therefore reads as a constant value. That value flips only when the programmed delay carries a data transition across the clock edge.

The block owns no delay cells. It steers external tap-programmable delay lines through a select mask, a one-cycle enable and a direction bit, and keeps a mirror of every line's tap count. On start it steps all lines to an initial offset. It then checks that the group is clear of the clock edge and, if it is not, moves all lines together. After that it calibrates lines 0 to 7 one after the other. Each line is stepped until its sample changes and then backed off by a quarter period. A done flag and the mirrored tap counts give the result.

Top module: `rdly_calib`

## Requirements
- R1: After reset, dly_ce and cal_done are low and every tap count in tap_mirror is 0. Line i's count sits at bits [i*TAP_W +: TAP_W].
- R2: On cal_start, all lines are stepped up together by INIT_TAPS (default 14) before any check of the group is made.
- R3: The group is judged clear only if, for WINDOW (default 10) consecutive cycles, all lines sample the same value (all zeros or all ones) and that value does not change.
- R4: After the first window that is not clear, all lines are stepped up together by ALIGN_STEP (default 2) taps and the window is run again.
- R5: After each later window that is not clear, all lines are stepped up together by one tap and the window is run again, until the group is clear or the tap limit is reached.
- R6: Lines are then calibrated strictly in order 0 to LANES-1, one at a time. The first sample of a line is stored, and the line is stepped up until a new sample differs from the stored one.
- R7: When a line's edge is found, that line is stepped down by QTR_TAPS (default 14) before the next line starts.
- R8: No line is ever stepped above TAP_LIMIT (default 55) or below 0. A line that reaches TAP_LIMIT without an edge is stepped down by QTR_TAPS.
- R9: Between any two delay commands there are at least SETTLE (default 3) cycles with dly_ce low.
- R10: A command is a single-cycle dly_ce pulse. dly_inc=1 means one tap up and dly_inc=0 means one tap down. dly_sel is all ones for group steps and one-hot for per-line steps. tap_mirror tracks the delay lines exactly.
- R11: cal_done rises after the last line's back-off, stays high until reset, and no command is issued while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Starts calibration from the idle state |
| dq_smp | input | LANES | Current captured sample of each data line |
| dly_sel | output | LANES | Lines addressed by the current command |
| dly_ce | output | 1 | One-cycle command enable |
| dly_inc | output | 1 | Command direction, 1 up, 0 down |
| cal_done | output | 1 | Calibration finished |
| tap_mirror | output | LANES*TAP_W | Tap count of each line |

## Verification
The assertions assume the following about the block's inputs. The delay lines sit at tap 0 when cal_start is given and apply each command within SETTLE cycles. QTR_TAPS is no larger than the first tap at which an edge can be found. A line's sample is steady except when its delay sits exactly on a transition. The bench resets its delay-line model together with the block and applies each step on the clock edge that ends the command cycle. It derives each sample from the tap plus a per-line offset within an eye of fixed width, and draws random values only at the exact transition tap. Directed offsets produce the straddle, edge-alignment and no-edge-before-limit cases, and random offsets cover the rest.

// File: rtl/rdcal_pkg.sv
package rdcal_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GRP,
        ST_WAIT,
        ST_CHK,
        ST_REF,
        ST_SRCH,
        ST_BACK,
        ST_DONE
    } cal_st_e;
endpackage

// File: rtl/rdcal_tap_bank.sv
module rdcal_tap_bank #(
    parameter int LANES     = 8,
    parameter int TAP_W     = 6,
    parameter int TAP_LIMIT = 55
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_ce,
    input  logic                        cmd_inc,
    input  logic [LANES-1:0]            cmd_sel,
    output logic [LANES-1:0][TAP_W-1:0] taps_o
);
    logic [LANES-1:0][TAP_W-1:0] tap_d, tap_q;

    always_comb begin
        tap_d = tap_q;
        for (int i = 0; i < LANES; i++) begin
            if (cmd_ce && cmd_sel[i]) begin
                tap_d[i] = cmd_inc ? tap_q[i] + 1'b1 : tap_q[i] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q <= '0;
        else        tap_q <= tap_d;
    end

    assign taps_o = tap_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        // R8
        tap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tap_q[g] <= TAP_W'(TAP_LIMIT));
        // R8
        no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_ce && !cmd_inc && cmd_sel[g]) |-> (tap_q[g] != '0));
    end
endmodule

// File: rtl/rdcal_window.sv
module rdcal_window #(
    parameter int LANES  = 8,
    parameter int WINDOW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [LANES-1:0] dq_i,
    output logic             fin_o,
    output logic             bad_o
);
    localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
        logic             ref_bit;
        logic             bad;
        logic             fin;
    } win_t;

    win_t win_d, win_q;
    logic uni, flag;

    always_comb begin
        win_d     = win_q;
        win_d.fin = 1'b0;
        uni       = (&dq_i) | ~(|dq_i);
        flag      = 1'b0;
        if (go_i) begin
            win_d.act = 1'b1;
            win_d.cnt = '0;
            win_d.bad = 1'b0;
        end else if (win_q.act) begin
            if (win_q.cnt == '0) win_d.ref_bit = dq_i[0];
            flag      = !uni || ((win_q.cnt != '0) && (dq_i[0] != win_q.ref_bit));
            win_d.bad = win_q.bad | flag;
            if (win_q.cnt == CNT_W'(WINDOW - 1)) begin
                win_d.act = 1'b0;
                win_d.fin = 1'b1;
            end else begin
                win_d.cnt = win_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign fin_o = win_q.fin;
    assign bad_o = win_q.bad;

    // R3
    fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !fin_o);
    // R3
    go_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |=> !fin_o);
endmodule

// File: rtl/rdly_calib.sv
module rdly_calib #(
    parameter int LANES      = 8,
    parameter int TAP_W      = 6,
    parameter int INIT_TAPS  = 14,
    parameter int QTR_TAPS   = 14,
    parameter int TAP_LIMIT  = 55,
    parameter int ALIGN_STEP = 2,
    parameter int WINDOW     = 10,
    parameter int SETTLE     = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cal_start,
    input  logic [LANES-1:0]         dq_smp,
    output logic [LANES-1:0]         dly_sel,
    output logic                     dly_ce,
    output logic                     dly_inc,
    output logic                     cal_done,
    output logic [LANES*TAP_W-1:0]   tap_mirror
);
    import rdcal_pkg::*;

    localparam int LANE_W = $clog2(LANES);
    localparam int SET_W  = $clog2(SETTLE + 1);
    localparam int STEP_W = TAP_W;
    localparam int GAP_W  = SET_W + 1;
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(SETTLE + 1);

    typedef struct packed {
        cal_st_e           st;
        cal_st_e           ret;
        logic [SET_W-1:0]  settle;
        logic [STEP_W-1:0] step;
        logic [LANE_W-1:0] lane;
        logic              ref_bit;
        logic              aligned;
        logic              ce;
        logic              inc;
        logic [LANES-1:0]  sel;
        logic              done;
        logic              chk_go;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic [LANES-1:0][TAP_W-1:0] taps;
    logic                        win_fin, win_bad;
    logic [TAP_W-1:0]            lane_tap, grp_tap;

    rdcal_tap_bank #(
        .LANES(LANES), .TAP_W(TAP_W), .TAP_LIMIT(TAP_LIMIT)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .cmd_ce(fsm_q.ce), .cmd_inc(fsm_q.inc), .cmd_sel(fsm_q.sel),
        .taps_o(taps)
    );

    rdcal_window #(
        .LANES(LANES), .WINDOW(WINDOW)
    ) u_win (
        .clk(clk), .rst_n(rst_n),
        .go_i(fsm_q.chk_go), .dq_i(dq_smp),
        .fin_o(win_fin), .bad_o(win_bad)
    );

    assign lane_tap = taps[fsm_q.lane];
    assign grp_tap  = taps[0];

    always_comb begin
        fsm_d        = fsm_q;
        fsm_d.ce     = 1'b0;
        fsm_d.chk_go = 1'b0;
        case (fsm_q.st)
            ST_IDLE: begin
                if (cal_start) begin
                    fsm_d.step    = STEP_W'(INIT_TAPS);
                    fsm_d.aligned = 1'b0;
                    fsm_d.st      = ST_GRP;
                end
            end
            ST_GRP: begin
                if (fsm_q.step == '0) begin
                    fsm_d.st     = ST_CHK;
                    fsm_d.chk_go = 1'b1;
                end else if (grp_tap >= TAP_W'(TAP_LIMIT)) begin
                    fsm_d.lane = '0;
                    fsm_d.st   = ST_REF;
                end else begin
                    fsm_d.ce     = 1'b1;
                    fsm_d.inc    = 1'b1;
                    fsm_d.sel    = '1;
                    fsm_d.step   = fsm_q.step - 1'b1;
                    fsm_d.settle = SET_W'(SETTLE);
                    fsm_d.ret    = ST_GRP;
                    fsm_d.st     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (fsm_q.settle == '0) fsm_d.st = fsm_q.ret;
                else                    fsm_d.settle = fsm_q.settle - 1'b1;
            end
            ST_CHK: begin
                if (win_fin) begin
                    if (win_bad) begin
                        fsm_d.step    = fsm_q.aligned ? STEP_W'(1) : STEP_W'(ALIGN_STEP);
                        fsm_d.aligned = 1'b1;
                        fsm_d.st      = ST_GRP;
                    end else begin
                        fsm_d.lane = '0;
                        fsm_d.st   = ST_REF;
                    end
                end
            end
            ST_REF: begin
                fsm_d.ref_bit = dq_smp[fsm_q.lane];
                if (lane_tap >= TAP_W'(TAP_LIMIT)) begin
                    fsm_d.step = STEP_W'(QTR_TAPS);
                    fsm_d.st   = ST_BACK;
                end else begin
                    fsm_d.ce     = 1'b1;
                    fsm_d.inc    = 1'b1;
                    fsm_d.sel    = LANES'(1) << fsm_q.lane;
                    fsm_d.settle = SET_W'(SETTLE);
                    fsm_d.ret    = ST_SRCH;
                    fsm_d.st     = ST_WAIT;
                end
            end
            ST_SRCH: begin
                if ((dq_smp[fsm_q.lane] != fsm_q.ref_bit) ||
                    (lane_tap >= TAP_W'(TAP_LIMIT))) begin
                    fsm_d.step = STEP_W'(QTR_TAPS);
                    fsm_d.st   = ST_BACK;
                end else begin
                    fsm_d.ce     = 1'b1;
                    fsm_d.inc    = 1'b1;
                    fsm_d.sel    = LANES'(1) << fsm_q.lane;
                    fsm_d.settle = SET_W'(SETTLE);
                    fsm_d.ret    = ST_SRCH;
                    fsm_d.st     = ST_WAIT;
                end
            end
            ST_BACK: begin
                if (fsm_q.step == '0) begin
                    if (fsm_q.lane == LANE_W'(LANES - 1)) begin
                        fsm_d.st = ST_DONE;
                    end else begin
                        fsm_d.lane = fsm_q.lane + 1'b1;
                        fsm_d.st   = ST_REF;
                    end
                end else begin
                    fsm_d.ce     = 1'b1;
                    fsm_d.inc    = 1'b0;
                    fsm_d.sel    = LANES'(1) << fsm_q.lane;
                    fsm_d.step   = fsm_q.step - 1'b1;
                    fsm_d.settle = SET_W'(SETTLE);
                    fsm_d.ret    = ST_BACK;
                    fsm_d.st     = ST_WAIT;
                end
            end
            ST_DONE: begin
                fsm_d.done = 1'b1;
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q     <= '0;
            fsm_q.st  <= ST_IDLE;
            fsm_q.ret <= ST_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign dly_sel    = fsm_q.sel;
    assign dly_ce     = fsm_q.ce;
    assign dly_inc    = fsm_q.inc;
    assign cal_done   = fsm_q.done;
    assign tap_mirror = taps;

    logic [GAP_W-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              gap_q <= GAP_MAX;
        else if (dly_ce)         gap_q <= '0;
        else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
    end

    // R9
    settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dly_ce |-> (gap_q >= GAP_W'(SETTLE)));
    // R10
    sel_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dly_ce |-> ((&dly_sel) || ($countones(dly_sel) == 1)));
    // R10
    ce_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dly_ce |=> !dly_ce);
    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> cal_done);
    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> !dly_ce);
endmodule

// File: tb/rdly_calib_bench.sv
module rdly_calib_bench;
    localparam int LANES  = 8;
    localparam int TAP_W  = 6;
    localparam int INIT   = 14;
    localparam int QTR    = 14;
    localparam int LIMIT  = 55;
    localparam int ALIGN  = 2;
    localparam int SETTLE = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   cal_start = 1'b0;
    logic [LANES-1:0]       dq_smp;
    logic [LANES-1:0]       dly_sel;
    logic                   dly_ce, dly_inc, cal_done;
    logic [LANES*TAP_W-1:0] tap_mirror;

    always #2.5 clk = ~clk;

    rdly_calib u_rdly_calib (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .dq_smp(dq_smp),
        .dly_sel(dly_sel), .dly_ce(dly_ce), .dly_inc(dly_inc),
        .cal_done(cal_done), .tap_mirror(tap_mirror)
    );

    int off [LANES];
    int mtap[LANES];
    int eye = 28;
    bit jit_en = 1'b0;
    logic [LANES-1:0] jit = '0;
    int n_chk = 0, n_fail = 0;
    int mon_err = 0, idle_ct = 100, grp_cap = -1;
    bit seen_line = 1'b0;
    int exp_tap[LANES];
    int exp_grp;

    // delay line model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LANES; i++) mtap[i] <= 0;
        end else if (dly_ce) begin
            for (int i = 0; i < LANES; i++)
                if (dly_sel[i]) mtap[i] <= dly_inc ? mtap[i] + 1 : mtap[i] - 1;
        end
    end

    always @(negedge clk) jit <= LANES'($urandom);

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            if (jit_en && (((mtap[i] + off[i]) % eye) == 0)) dq_smp[i] = jit[i];
            else dq_smp[i] = (((mtap[i] + off[i]) / eye) % 2) == 1;
        end
    end

    // command monitor (R8, R9, R10, R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (dly_ce) begin
                if (idle_ct < SETTLE) mon_err++;
                idle_ct = 0;
                if (!(&dly_sel) && ($countones(dly_sel) != 1)) mon_err++;
                if (cal_done) mon_err++;
                if (($countones(dly_sel) == 1) && !seen_line) begin
                    seen_line = 1'b1;
                    grp_cap = mtap[0];
                end
            end else begin
                idle_ct++;
            end
            for (int i = 0; i < LANES; i++)
                if (mtap[i] > LIMIT || mtap[i] < 0) mon_err++;
        end
    end

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int smp(int i, int t);
        return ((t + off[i]) / eye) % 2;
    endfunction

    function automatic bit clear_at(int t);
        for (int i = 1; i < LANES; i++) if (smp(i, t) != smp(0, t)) return 1'b0;
        return 1'b1;
    endfunction

    // expected values from R2..R8
    task automatic predict();
        int t = INIT;
        bit aligned = 1'b0;
        bit hit = 1'b0;
        while (!hit && !clear_at(t)) begin
            int n = aligned ? 1 : ALIGN;
            aligned = 1'b1;
            for (int k = 0; k < n; k++) begin
                if (t >= LIMIT) begin hit = 1'b1; break; end
                t++;
            end
        end
        exp_grp = t;
        for (int l = 0; l < LANES; l++) begin
            int e = t;
            int r = smp(l, e);
            while (e < LIMIT) begin
                e++;
                if (smp(l, e) != r) break;
            end
            exp_tap[l] = e - QTR;
        end
    endtask

    task automatic run(string tag, bit jitter, int grp_override);
        int cyc = 0;
        rst_n = 1'b0;
        jit_en = jitter;
        predict();
        if (grp_override >= 0) exp_grp = grp_override;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dly_ce == 1'b0, "R1 ce", int'(dly_ce), 0);
        chk(cal_done == 1'b0, "R1 done", int'(cal_done), 0);
        chk(tap_mirror == '0, "R1 taps", int'(tap_mirror[TAP_W-1:0]), 0);
        mon_err = 0; idle_ct = 100; seen_line = 1'b0; grp_cap = -1;
        rst_n = 1'b1;
        @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        while (!cal_done && cyc < 20000) begin @(negedge clk); cyc++; end
        chk(cal_done == 1'b1, {"R11 done ", tag}, int'(cal_done), 1);
        // R2 R3 R4 R5 group tap at first per-line command
        chk(grp_cap == exp_grp, {"R2/R3 R4 R5 group tap ", tag}, grp_cap, exp_grp);
        for (int l = 0; l < LANES; l++) begin
            int a = int'(tap_mirror[l*TAP_W +: TAP_W]);
            // R6 R7 R8
            if (jitter)
                chk(a == exp_tap[l] || a == exp_tap[l] + 1, {"R6 R7 lane ", tag}, a, exp_tap[l]);
            else
                chk(a == exp_tap[l], {"R6 R7 R8 lane ", tag}, a, exp_tap[l]);
        end
        begin
            bit same = 1'b1;
            for (int l = 0; l < LANES; l++)
                if (int'(tap_mirror[l*TAP_W +: TAP_W]) != mtap[l]) same = 1'b0;
            chk(same, {"R10 mirror ", tag}, int'(same), 1);
        end
        repeat (20) @(negedge clk);
        chk(cal_done == 1'b1, {"R11 hold ", tag}, int'(cal_done), 1);
        chk(mon_err == 0, {"R8 R9 R10 R11 monitor ", tag}, mon_err, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // typical: all lines in the same half, distinct offsets
        eye = 28;
        for (int i = 0; i < LANES; i++) off[i] = i;
        run("typical", 1'b0, -1);
        // straddle: two groups of lines on opposite sides of an edge
        for (int i = 0; i < LANES; i++) off[i] = (i < 4) ? 10 : 16;
        run("straddle", 1'b0, -1);
        // edge alignment: every line exactly on an edge after init
        for (int i = 0; i < LANES; i++) off[i] = 14;
        run("align", 1'b1, INIT + ALIGN);
        // no edge before the tap limit
        eye = 60;
        for (int i = 0; i < LANES; i++) off[i] = 0;
        run("limit", 1'b0, -1);
        eye = 28;
        for (int r = 0; r < 20; r++) begin
            for (int i = 0; i < LANES; i++) off[i] = int'($urandom_range(0, 27));
            run("random", 1'b0, -1);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule